// File: doc/BRIEF.md
# Isolated Serial Converter Transaction Engine

This block runs one framed serial exchange with an external sigma-delta converter that sits behind slow opto-isolated lines. A single-cycle `start` launches either a write of the 24-bit configuration word or a read of the data register. The caller chooses the direction, the target register and a long (24-bit) or short (16-bit) word. The engine then drives the serial clock, the outbound data line, the register-select line and two active-low frame strobes, one for sending and one for receiving. It shifts the inbound data line in and returns the received word together with a one-cycle `done`.

Every level the engine holds on the serial clock lasts a fixed number of system clock cycles, set by `HALF_CYC`. The default meets a 100 µs minimum half-period at a 250 MHz system clock. The caller must confirm that the converter is ready before it issues a read, and it issues one transaction at a time.

Top module: `iso_adc_xact`

## Requirements
- R1: After reset, `sclk` and `sdo` are low, `tx_fs_n` and `rx_fs_n` are high, and `busy` and `done` are low.
- R2: A `start` while idle raises `busy` in the next cycle. `busy` stays high until the frame strobe is released. A `start` while `busy` is high is ignored and produces no extra frame.
- R3: `reg_sel` is driven high for the data register (`data_sel`=1) and low for the configuration register. It takes its value one half-period before the frame strobe falls and holds that value until the strobe rises.
- R4: A write (`rd_sel`=0) lowers only `tx_fs_n`, and a read (`rd_sel`=1) lowers only `rx_fs_n`. The strobe stays low for the whole frame, and the two strobes are never low together.
- R5: A frame carries exactly 24 rising edges of `sclk` when `long_sel`=1 and 16 when `long_sel`=0. `sclk` is low outside those pulses and after the frame.
- R6: On a write, bits leave MSB first. Each bit is set on `sdo` while `sclk` is low, including the first bit before the first rising edge, and is held while `sclk` is high. A short write sends `wr_word[15:0]`, and a long write sends `wr_word[23:0]`.
- R7: On a read, `sdi` is sampled in the last system cycle of each high half-period, MSB first. A short read returns the 16 bits right-aligned in `rd_word`, with bits 23:16 zero.
- R8: Every high and low level of `sclk` inside a frame, and the lead from the strobe falling to the first rising edge, lasts exactly `HALF_CYC` system cycles.
- R9: `done` is a one-cycle pulse in the cycle where `busy` falls and the strobe returns high. `rd_word` updates with `done` after a read and keeps its value through a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle transaction request |
| rd_sel | input | 1 | 1 = read, 0 = write |
| data_sel | input | 1 | 1 = data register, 0 = configuration register |
| long_sel | input | 1 | 1 = 24-bit word, 0 = 16-bit word |
| wr_word | input | 24 | Word to send on a write |
| sdi | input | 1 | Serial data from converter |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data to converter |
| reg_sel | output | 1 | Register select line |
| tx_fs_n | output | 1 | Transmit frame strobe, active low |
| rx_fs_n | output | 1 | Receive frame strobe, active low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_word | output | 24 | Last word read |

## Verification
A wrong phase or bit count inside the engine shows up at the ports within one frame. The converter model would see the wrong number of edges, and the captured word would appear shifted by one or more bits. A stray shift during a write would move `sdo` while `sclk` is high, and that is visible within one half-period. A timer that ends a phase early shortens a measured `sclk` level in the same pulse. A stuck direction flag lowers the wrong strobe at the very start of the frame.

// File: rtl/iso_adc_xact.sv
module iso_adc_xact #(
  parameter int HALF_CYC   = 25000,
  parameter int WORD_W     = 24,
  parameter int SHORT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_sel,
  input  logic              data_sel,
  input  logic              long_sel,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              sdi,
  output logic              sclk,
  output logic              sdo,
  output logic              reg_sel,
  output logic              tx_fs_n,
  output logic              rx_fs_n,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rd_word
);

  localparam int CW = $clog2(HALF_CYC + 1);
  localparam int BW = $clog2(WORD_W + 1);
  localparam int PAD = WORD_W - SHORT_W;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LEAD, S_HI, S_LO} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   nbit;
  logic            is_rd, is_long;
  logic [WORD_W-1:0] tx, rx;
  logic            last, in_frame;
  logic [BW-1:0]   nbit_end;

  assign last     = (cnt == CW'(HALF_CYC - 1));
  assign in_frame = (st == S_LEAD) || (st == S_HI) || (st == S_LO);
  assign nbit_end = is_long ? BW'(WORD_W) : BW'(SHORT_W);

  assign sclk    = (st == S_HI);
  assign busy    = (st != S_IDLE);
  assign tx_fs_n = !(in_frame && !is_rd);
  assign rx_fs_n = !(in_frame && is_rd);
  assign sdo     = in_frame && !is_rd && tx[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      nbit    <= '0;
      is_rd   <= 1'b0;
      is_long <= 1'b0;
      reg_sel <= 1'b0;
      tx      <= '0;
      rx      <= '0;
      done    <= 1'b0;
      rd_word <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE || last) cnt <= '0;
      else                      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st      <= S_SETUP;
          is_rd   <= rd_sel;
          is_long <= long_sel;
          reg_sel <= data_sel;
          nbit    <= '0;
          rx      <= '0;
          tx      <= long_sel ? wr_word : {wr_word[SHORT_W-1:0], {PAD{1'b0}}};
        end
        S_SETUP: if (last) st <= S_LEAD;
        S_LEAD:  if (last) st <= S_HI;
        S_HI: if (last) begin
          st   <= S_LO;
          nbit <= nbit + 1'b1;
          if (is_rd) rx <= {rx[WORD_W-2:0], sdi};
          else       tx <= {tx[WORD_W-2:0], 1'b0};
        end
        S_LO: if (last) begin
          if (nbit == nbit_end) begin
            st   <= S_IDLE;
            done <= 1'b1;
            if (is_rd) rd_word <= rx;
          end else begin
            st <= S_HI;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/iso_adc_xact_chk.sv
module iso_adc_xact_chk #(
  parameter int HALF_CYC = 25000
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sdo,
  input logic reg_sel,
  input logic tx_fs_n,
  input logic rx_fs_n,
  input logic busy,
  input logic done
);

  logic [31:0] hi_run;
  logic        fs_low;

  assign fs_low = !tx_fs_n || !rx_fs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= sclk ? hi_run + 1 : '0;
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!tx_fs_n && !rx_fs_n));

  // R5
  clk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (busy && fs_low));

  // R3
  regsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_low && $past(fs_low)) |-> $stable(reg_sel));

  // R6
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !fs_low));

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  hi_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_run >= HALF_CYC));

endmodule

bind iso_adc_xact iso_adc_xact_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdo(sdo), .reg_sel(reg_sel),
  .tx_fs_n(tx_fs_n), .rx_fs_n(rx_fs_n), .busy(busy), .done(done)
);

// File: tb/sim_iso_adc_xact.sv
module sim_iso_adc_xact;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic rd_sel = 1'b0, data_sel = 1'b0, long_sel = 1'b0;
  logic [23:0] wr_word = '0;
  logic sdi;
  logic sclk, sdo, reg_sel, tx_fs_n, rx_fs_n, busy, done;
  logic [23:0] rd_word;

  always #2 clk = ~clk;

  iso_adc_xact #(.HALF_CYC(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_sel(rd_sel),
    .data_sel(data_sel), .long_sel(long_sel), .wr_word(wr_word), .sdi(sdi),
    .sclk(sclk), .sdo(sdo), .reg_sel(reg_sel), .tx_fs_n(tx_fs_n),
    .rx_fs_n(rx_fs_n), .busy(busy), .done(done), .rd_word(rd_word)
  );

  int checks = 0, errors = 0;

  // converter model, all state written here on the falling system edge
  logic [23:0] mdl_word = '0;
  logic        mdl_long = 1'b1;
  int          idx = 0, pulses = 0, wframes = 0, rframes = 0;
  int          min_hi = 1000, min_lo = 1000, min_lead = 1000;
  int          hi_run = 0, lo_run = 0, lead_run = 0;
  int          sdo_moves = 0, rsel_moves = 0;
  logic [23:0] cap = '0;
  logic        rsel_at_fs = 1'b0;
  logic        p_sclk = 1'b0, p_tx = 1'b1, p_rx = 1'b1, p_sdo = 1'b0, p_rsel = 1'b0;
  logic        led = 1'b0;

  assign sdi = mdl_word[idx];

  always @(negedge clk) begin
    if (p_rx && !rx_fs_n) begin idx <= mdl_long ? 23 : 15; rframes <= rframes + 1; end
    else if (p_sclk && !sclk && !rx_fs_n && idx > 0) idx <= idx - 1;
    if (p_tx && !tx_fs_n) wframes <= wframes + 1;
    if ((p_tx && !tx_fs_n) || (p_rx && !rx_fs_n)) begin rsel_at_fs <= reg_sel; led <= 1'b1; lead_run <= 1; end
    else if (led && !sclk) lead_run <= lead_run + 1;
    if (!p_sclk && sclk) begin
      pulses <= pulses + 1;
      if (!tx_fs_n) cap <= {cap[22:0], sdo};
      if (led) begin led <= 1'b0; if (lead_run < min_lead) min_lead <= lead_run; end
      else if (lo_run < min_lo) min_lo <= lo_run;
    end
    if (sclk) hi_run <= hi_run + 1; else hi_run <= 0;
    if (!sclk && !(tx_fs_n && rx_fs_n)) lo_run <= lo_run + 1; else lo_run <= 0;
    if (p_sclk && !sclk && hi_run < min_hi) min_hi <= hi_run;
    if (p_sclk && !sclk) lo_run <= 1;
    if (p_sclk && sclk && sdo != p_sdo) sdo_moves <= sdo_moves + 1;
    if (!(tx_fs_n && rx_fs_n) && !(p_tx && p_rx) && reg_sel != p_rsel) rsel_moves <= rsel_moves + 1;
    p_sclk <= sclk; p_tx <= tx_fs_n; p_rx <= rx_fs_n; p_sdo <= sdo; p_rsel <= reg_sel;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    if (!ok) begin checks++; errors++; $display("FAIL R9 watchdog actual=0 expected=1"); end
  endtask

  // {rd, data, long, wr_word, model_word}
  localparam int NV = 6;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 24'h22004E, 24'h000000},
    {1'b1, 1'b1, 1'b1, 24'h000000, 24'hC0FFEE},
    {1'b0, 1'b0, 1'b0, 24'h12A5C3, 24'h000000},
    {1'b1, 1'b1, 1'b0, 24'h000000, 24'h7E8001},
    {1'b1, 1'b0, 1'b1, 24'h000000, 24'h800001},
    {1'b0, 1'b1, 1'b1, 24'hFFFFFF, 24'h000000}
  };

  logic [23:0] last_rd = '0;

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    chk("R1 sclk", {31'b0, sclk}, 0);
    chk("R1 sdo", {31'b0, sdo}, 0);
    chk("R1 tx_fs_n", {31'b0, tx_fs_n}, 1);
    chk("R1 rx_fs_n", {31'b0, rx_fs_n}, 1);
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 done", {31'b0, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      automatic logic        rd = VEC[v][50];
      automatic logic        dr = VEC[v][49];
      automatic logic        lg = VEC[v][48];
      automatic logic [23:0] ww = VEC[v][47:24];
      automatic logic [23:0] mw = VEC[v][23:0];
      automatic int p0 = pulses, w0 = wframes, r0 = rframes, s0 = sdo_moves, g0 = rsel_moves;
      automatic int n = lg ? 24 : 16;
      mdl_word = mw; mdl_long = lg;
      rd_sel = rd; data_sel = dr; long_sel = lg; wr_word = ww; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 busy after start", {31'b0, busy}, 1);
      chk("R3 reg_sel early", {31'b0, reg_sel}, {31'b0, dr});
      wait_done(ok);
      chk("R9 strobes released at done", {30'b0, tx_fs_n, rx_fs_n}, 3);
      chk("R9 busy low at done", {31'b0, busy}, 0);
      chk("R5 pulse count", pulses - p0, n);
      chk("R5 sclk low after", {31'b0, sclk}, 0);
      chk("R4 write strobe frames", wframes - w0, rd ? 0 : 1);
      chk("R4 read strobe frames", rframes - r0, rd ? 1 : 0);
      chk("R3 reg_sel at strobe", {31'b0, rsel_at_fs}, {31'b0, dr});
      chk("R3 reg_sel stable", rsel_moves - g0, 0);
      if (rd) begin
        last_rd = lg ? mw : {8'h00, mw[15:0]};
        chk("R7 read word", {8'b0, rd_word}, {8'b0, last_rd});
      end else begin
        chk("R6 write bits", lg ? {8'b0, cap} : {16'b0, cap[15:0]}, lg ? {8'b0, ww} : {16'b0, ww[15:0]});
        chk("R6 sdo stable high", sdo_moves - s0, 0);
        chk("R9 rd_word held", {8'b0, rd_word}, {8'b0, last_rd});
      end
      @(negedge clk);
      chk("R9 done one cycle", {31'b0, done}, 0);
    end
    chk("R8 high width", min_hi, HALF);
    chk("R8 low width", min_lo, HALF);
    chk("R8 lead width", min_lead, HALF);

    begin
      automatic int w0 = wframes, r0 = rframes;
      rd_sel = 1'b0; data_sel = 1'b0; long_sel = 1'b0; wr_word = 24'h00BEEF; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      rd_sel = 1'b1; start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_done(ok);
      repeat (30) @(negedge clk);
      chk("R2 no extra frame busy", {31'b0, busy}, 0);
      chk("R2 one write frame", wframes - w0, 1);
      chk("R2 no read frame", rframes - r0, 0);
      chk("R6 short write under busy start", {16'b0, cap[15:0]}, 32'h0000BEEF);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule